// File: doc/BRIEF.md
# Power domain on/off sequencer

This block switches one power domain of a chip on and off. A controller write, guarded by a key, starts either a power-up or a power-down sequence. The sequencer then steps the domain's control bits one at a time in a fixed order: main and secondary power switches, clock gate, isolation, reset and SRAM power-down. Before it moves past certain steps it waits for confirmation from the domain. These confirmations are two independent power-status inputs, an SRAM power-down acknowledge field, and a protection handshake with the interconnect that fences the domain's bus ports.

Every wait is bounded by a cycle counter. When a wait runs out, the sequence stops with a sticky error and the control bits keep the values they had at that moment. The block reports a one-cycle completion pulse, a busy flag and whether the domain is currently on. The bus-protection mask, the SRAM power-down and acknowledge masks, and the timeout are parameters, so one sequencer can be instantiated for each domain with that domain's configuration.

Top module: `pwr_dom_seq`

## Requirements
- R1: A write (`wr_valid` high) is accepted only when `wr_key` equals 16'h0B16 and `wr_arm` is 1. `wr_on` selects power-up (1) or power-down (0). Any other write changes nothing.
- R2: After reset, `ctl_word` holds bit0=0 (reset asserted, active low), bit1=1 (isolation on), bit2=0 (main switch), bit3=0 (secondary switch), bit4=1 (clock disabled), bits 11:8 = SRAM_PDN_MASK, and all other bits 0. Also after reset, `prot_en` equals PROT_MASK, and `done`, `err`, `busy` and `is_on` are all 0.
- R3: Power-up runs these steps in order: set bit2, set bit3, wait for the domain to report on, clear bit4, clear bit1, set bit0, clear the SRAM_PDN_MASK bits, wait for the SRAM acknowledge, then release protection.
- R4: The domain counts as on only when `sta_a` and `sta_b` are both 1, and as off only when both are 0. A mixed pair satisfies neither wait.
- R5: Power-up waits until every SRAM_ACK_MASK bit of `sram_ack` is 0. Power-down waits until every such bit is 1. With SRAM_PDN_MASK zero, bits 11:8 never change.
- R6: Power-down runs these steps in order: assert protection and wait for it, set the SRAM_PDN_MASK bits, wait for the SRAM acknowledge, set bit1, clear bit0, set bit4, clear bit2, clear bit3, then wait for the domain to report off.
- R7: Asserting protection sets the PROT_MASK bits of `prot_en` and waits until all of them read 1 on `prot_sta`. Releasing protection clears those bits and waits until all of them read 0. With PROT_MASK zero, both handshakes are skipped and take no cycles.
- R8: At most one step of `ctl_word` changes per clock, and each value holds for at least one cycle.
- R9: A wait that is not satisfied within TIMEOUT_CYC cycles of entering it ends the sequence. `err` is set and stays set until reset, `busy` returns to 0, `ctl_word` and `prot_en` keep their values, and no `done` pulse is produced.
- R10: Writes that arrive while `busy` is high are ignored. An accepted write that asks for the state the domain is already in gives `done` in the next cycle and changes no control bit.
- R11: `done` is a single-cycle pulse. `is_on` takes its new value in the same cycle that `done` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Controller write strobe |
| wr_key | input | 16 | Key half of the write word |
| wr_arm | input | 1 | Enable bit of the write word |
| wr_on | input | 1 | Requested state: 1 up, 0 down |
| sta_a | input | 1 | First power-status input |
| sta_b | input | 1 | Second power-status input |
| sram_ack | input | 4 | SRAM power-down acknowledge field |
| prot_sta | input | PROT_W | Bus-protection status from interconnect |
| ctl_word | output | 12 | Domain control bits |
| prot_en | output | PROT_W | Bus-protection enable to interconnect |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Sticky timeout error |
| busy | output | 1 | Sequence in progress |
| is_on | output | 1 | Domain currently on |

## Verification
The bench builds two instances. The first uses an 8-bit protection mask of 8'h0C, an SRAM acknowledge mask of 4'b0011 and a 16-cycle timeout. The short timeout makes timeout aborts reachable in a few dozen cycles, and it pins down the exact cycle at which `err` rises, both on a stuck mixed status pair and on a stuck protection acknowledge. The second instance has zero protection and SRAM masks. That makes the skipped handshakes and the no-op SRAM steps visible as exact cycle counts from request to `done`, and as control bits that never move.

// File: rtl/pds_pkg.sv
package pds_pkg;

  localparam int unsigned CTL_W     = 12;
  localparam int unsigned SRAM_LSB  = 8;
  localparam int unsigned SRAM_W    = 4;
  localparam int unsigned KEY_W     = 16;
  localparam logic [15:0] WR_KEY    = 16'h0B16;

  // control word bit positions
  localparam int unsigned CB_RST_N  = 0;
  localparam int unsigned CB_ISO    = 1;
  localparam int unsigned CB_SW1    = 2;
  localparam int unsigned CB_SW2    = 3;
  localparam int unsigned CB_CLKDIS = 4;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_ON_SW1,
    ST_ON_SW2,
    ST_ON_WSTA,
    ST_ON_CLK,
    ST_ON_ISO,
    ST_ON_RST,
    ST_ON_SRAM,
    ST_ON_WACK,
    ST_ON_PROT,
    ST_ON_WPROT,
    ST_OFF_PROT,
    ST_OFF_WPROT,
    ST_OFF_SRAM,
    ST_OFF_WACK,
    ST_OFF_ISO,
    ST_OFF_RST,
    ST_OFF_CLK,
    ST_OFF_SW1,
    ST_OFF_SW2,
    ST_OFF_WSTA
  } pds_state_e;

endpackage

// File: rtl/pds_key_check.sv
module pds_key_check
  import pds_pkg::*;
(
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_arm,
  input  logic             wr_on,
  output logic             accept,
  output logic             want_on
);

  logic key_match;

  assign key_match = (wr_key == WR_KEY);
  assign accept    = wr_valid && key_match && wr_arm;
  assign want_on   = wr_on;

endmodule

// File: rtl/pds_cond_eval.sv
module pds_cond_eval
  import pds_pkg::*;
#(
  parameter int unsigned       PROT_W        = 32,
  parameter logic [SRAM_W-1:0] SRAM_ACK_MASK = 4'hF,
  parameter logic [PROT_W-1:0] PROT_MASK     = '0
) (
  input  logic              sta_a,
  input  logic              sta_b,
  input  logic [SRAM_W-1:0] sram_ack,
  input  logic [PROT_W-1:0] prot_sta,
  output logic              dom_up,
  output logic              dom_down,
  output logic              ack_clear,
  output logic              ack_full,
  output logic              prot_set_ok,
  output logic              prot_clr_ok
);

  logic [SRAM_W-1:0] ack_sel;
  logic [PROT_W-1:0] prot_sel;

  assign ack_sel  = sram_ack & SRAM_ACK_MASK;
  assign prot_sel = prot_sta & PROT_MASK;

  // both status inputs must agree; a mixed pair is transitional
  assign dom_up      = sta_a && sta_b;
  assign dom_down    = !sta_a && !sta_b;
  assign ack_clear   = (ack_sel == '0);
  assign ack_full    = (ack_sel == SRAM_ACK_MASK);
  assign prot_set_ok = (prot_sel == PROT_MASK);
  assign prot_clr_ok = (prot_sel == '0);

endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (!last) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = run || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT - 1)); // R9

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pds_pkg::*;
#(
  parameter int unsigned       TIMEOUT_CYC   = 10000,
  parameter logic [3:0]        SRAM_PDN_MASK = 4'hF,
  parameter logic [3:0]        SRAM_ACK_MASK = 4'hF,
  parameter int unsigned       PROT_W        = 32,
  parameter logic [PROT_W-1:0] PROT_MASK     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [15:0]       wr_key,
  input  logic              wr_arm,
  input  logic              wr_on,
  input  logic              sta_a,
  input  logic              sta_b,
  input  logic [3:0]        sram_ack,
  input  logic [PROT_W-1:0] prot_sta,
  output logic [11:0]       ctl_word,
  output logic [PROT_W-1:0] prot_en,
  output logic              done,
  output logic              err,
  output logic              busy,
  output logic              is_on
);

  localparam bit HAS_PROT = (PROT_MASK != '0);

  localparam logic [CTL_W-1:0] CTL_RESET =
    (CTL_W'(SRAM_PDN_MASK) << SRAM_LSB) |
    (CTL_W'(1) << CB_ISO) |
    (CTL_W'(1) << CB_CLKDIS);

  pds_state_e        state_q, state_d;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [PROT_W-1:0] prot_q, prot_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              on_q, on_d;
  logic              wait_run, tmo;
  logic              ctl_en, prot_en_ce, state_en, err_en, on_en;

  logic accept, want_on;
  logic dom_up, dom_down, ack_clear, ack_full, prot_set_ok, prot_clr_ok;

  pds_key_check u_key (
    .wr_valid (wr_valid),
    .wr_key   (wr_key),
    .wr_arm   (wr_arm),
    .wr_on    (wr_on),
    .accept   (accept),
    .want_on  (want_on)
  );

  pds_cond_eval #(
    .PROT_W        (PROT_W),
    .SRAM_ACK_MASK (SRAM_ACK_MASK),
    .PROT_MASK     (PROT_MASK)
  ) u_cond (
    .sta_a       (sta_a),
    .sta_b       (sta_b),
    .sram_ack    (sram_ack),
    .prot_sta    (prot_sta),
    .dom_up      (dom_up),
    .dom_down    (dom_down),
    .ack_clear   (ack_clear),
    .ack_full    (ack_full),
    .prot_set_ok (prot_set_ok),
    .prot_clr_ok (prot_clr_ok)
  );

  pds_wait_timer #(
    .LIMIT (TIMEOUT_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (wait_run),
    .last  (tmo)
  );

  // next-state logic: one control step per state, waits bounded by timer
  always_comb begin
    state_d  = state_q;
    ctl_d    = ctl_q;
    prot_d   = prot_q;
    done_d   = 1'b0;
    err_d    = err_q;
    on_d     = on_q;
    wait_run = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (want_on == on_q) begin
            done_d = 1'b1;
          end else if (want_on) begin
            state_d = ST_ON_SW1;
          end else begin
            state_d = HAS_PROT ? ST_OFF_PROT : ST_OFF_SRAM;
          end
        end
      end

      // ---------------- power-up ----------------
      ST_ON_SW1: begin
        ctl_d[CB_SW1] = 1'b1;
        state_d       = ST_ON_SW2;
      end
      ST_ON_SW2: begin
        ctl_d[CB_SW2] = 1'b1;
        state_d       = ST_ON_WSTA;
      end
      ST_ON_WSTA: begin
        wait_run = 1'b1;
        if (dom_up) begin
          state_d = ST_ON_CLK;
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_ON_CLK: begin
        ctl_d[CB_CLKDIS] = 1'b0;
        state_d          = ST_ON_ISO;
      end
      ST_ON_ISO: begin
        ctl_d[CB_ISO] = 1'b0;
        state_d       = ST_ON_RST;
      end
      ST_ON_RST: begin
        ctl_d[CB_RST_N] = 1'b1;
        state_d         = ST_ON_SRAM;
      end
      ST_ON_SRAM: begin
        ctl_d[SRAM_LSB +: SRAM_W] = ctl_q[SRAM_LSB +: SRAM_W] & ~SRAM_PDN_MASK;
        state_d                   = ST_ON_WACK;
      end
      ST_ON_WACK: begin
        wait_run = 1'b1;
        if (ack_clear) begin
          if (HAS_PROT) begin
            state_d = ST_ON_PROT;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            on_d    = 1'b1;
          end
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_ON_PROT: begin
        prot_d  = prot_q & ~PROT_MASK;
        state_d = ST_ON_WPROT;
      end
      ST_ON_WPROT: begin
        wait_run = 1'b1;
        if (prot_clr_ok) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          on_d    = 1'b1;
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end

      // ---------------- power-down ----------------
      ST_OFF_PROT: begin
        prot_d  = prot_q | PROT_MASK;
        state_d = ST_OFF_WPROT;
      end
      ST_OFF_WPROT: begin
        wait_run = 1'b1;
        if (prot_set_ok) begin
          state_d = ST_OFF_SRAM;
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_OFF_SRAM: begin
        ctl_d[SRAM_LSB +: SRAM_W] = ctl_q[SRAM_LSB +: SRAM_W] | SRAM_PDN_MASK;
        state_d                   = ST_OFF_WACK;
      end
      ST_OFF_WACK: begin
        wait_run = 1'b1;
        if (ack_full) begin
          state_d = ST_OFF_ISO;
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_OFF_ISO: begin
        ctl_d[CB_ISO] = 1'b1;
        state_d       = ST_OFF_RST;
      end
      ST_OFF_RST: begin
        ctl_d[CB_RST_N] = 1'b0;
        state_d         = ST_OFF_CLK;
      end
      ST_OFF_CLK: begin
        ctl_d[CB_CLKDIS] = 1'b1;
        state_d          = ST_OFF_SW1;
      end
      ST_OFF_SW1: begin
        ctl_d[CB_SW1] = 1'b0;
        state_d       = ST_OFF_SW2;
      end
      ST_OFF_SW2: begin
        ctl_d[CB_SW2] = 1'b0;
        state_d       = ST_OFF_WSTA;
      end
      ST_OFF_WSTA: begin
        wait_run = 1'b1;
        if (dom_down) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          on_d    = 1'b0;
        end else if (tmo) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign state_en   = (state_d != state_q);
  assign ctl_en     = (ctl_d != ctl_q);
  assign prot_en_ce = (prot_d != prot_q);
  assign err_en     = (err_d != err_q);
  assign on_en      = (on_d != on_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= CTL_RESET;
      prot_q  <= PROT_MASK;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      on_q    <= 1'b0;
    end else begin
      done_q <= done_d;
      if (state_en) begin
        state_q <= state_d;
      end
      if (ctl_en) begin
        ctl_q <= ctl_d;
      end
      if (prot_en_ce) begin
        prot_q <= prot_d;
      end
      if (err_en) begin
        err_q <= err_d;
      end
      if (on_en) begin
        on_q <= on_d;
      end
    end
  end

  assign ctl_word = ctl_q;
  assign prot_en  = prot_q;
  assign done     = done_q;
  assign err      = err_q;
  assign busy     = (state_q != ST_IDLE);
  assign is_on    = on_q;

  AST_IDLE_HOLDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> $stable(ctl_q)); // R10

  AST_CLK_AFTER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[CB_CLKDIS]) |-> $past(dom_up, 2)); // R4

  AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[CB_RST_N]) |-> !ctl_q[CB_ISO]); // R3

  AST_ISO_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[CB_ISO]) |-> $past(ack_full, 2)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9

endmodule

// File: tb/test_pwr_dom_seq.sv
module test_pwr_dom_seq;

  localparam int unsigned TMO   = 16;
  localparam int unsigned PW    = 8;
  localparam logic [7:0]  PMASK = 8'h0C;
  localparam logic [15:0] KEY   = 16'h0B16;

  // expected ctl_word after each step: 6 power-up steps, then 6 power-down steps
  localparam logic [11:0] TRACE_EXP [12] = '{
    12'hF16, 12'hF1E, 12'hF0E, 12'hF0C, 12'hF0D, 12'h00D,
    12'hF0D, 12'hF0F, 12'hF0E, 12'hF1E, 12'hF1A, 12'hF12
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        wr_valid, wr_valid_b;
  logic [15:0] wr_key;
  logic        wr_arm, wr_on;

  logic          sta_a, sta_b;
  logic [3:0]    sram_ack;
  logic [PW-1:0] prot_sta;
  logic [11:0]   ctl;
  logic [PW-1:0] prot_en;
  logic          done, err, busy, is_on;

  logic          sta_a_b, sta_b_b;
  logic [11:0]   ctl_b;
  logic [PW-1:0] prot_en_b;
  logic          done_b, err_b, busy_b, is_on_b;

  logic lock_b_low, lock_prot_low;

  pwr_dom_seq #(
    .TIMEOUT_CYC (TMO), .SRAM_PDN_MASK (4'hF), .SRAM_ACK_MASK (4'b0011),
    .PROT_W (PW), .PROT_MASK (PMASK)
  ) i_pwr_dom_seq (
    .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_key (wr_key),
    .wr_arm (wr_arm), .wr_on (wr_on), .sta_a (sta_a), .sta_b (sta_b),
    .sram_ack (sram_ack), .prot_sta (prot_sta), .ctl_word (ctl),
    .prot_en (prot_en), .done (done), .err (err), .busy (busy), .is_on (is_on)
  );

  pwr_dom_seq #(
    .TIMEOUT_CYC (TMO), .SRAM_PDN_MASK (4'h0), .SRAM_ACK_MASK (4'h0),
    .PROT_W (PW), .PROT_MASK ('0)
  ) i_pwr_dom_seq_bare (
    .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid_b), .wr_key (wr_key),
    .wr_arm (wr_arm), .wr_on (wr_on), .sta_a (sta_a_b), .sta_b (sta_b_b),
    .sram_ack (4'h0), .prot_sta ('0), .ctl_word (ctl_b),
    .prot_en (prot_en_b), .done (done_b), .err (err_b), .busy (busy_b), .is_on (is_on_b)
  );

  // domain and interconnect model
  logic [1:0]    sa_p;
  logic [2:0]    sb_p;
  logic [1:0]    ack_p;
  logic [PW-1:0] pr_p0, pr_p1;
  always @(posedge clk) begin
    sa_p    <= {sa_p[0], ctl[2]};
    sb_p    <= {sb_p[1:0], ctl[3]};
    ack_p   <= {ack_p[0], (ctl[11:8] == 4'hF)};
    pr_p0   <= prot_en;
    pr_p1   <= pr_p0;
    sta_a_b <= ctl_b[2];
    sta_b_b <= ctl_b[3];
  end
  assign sta_a    = sa_p[1];
  assign sta_b    = sb_p[2] & !lock_b_low;
  assign sram_ack = {4{ack_p[1]}};
  assign prot_sta = lock_prot_low ? '0 : pr_p1;

  // step-change trace of the main instance
  logic [11:0] trace [64];
  int          tn = 0;
  logic [11:0] prev_ctl;
  always @(negedge clk) begin
    if (rst_n && (ctl != prev_ctl) && (tn < 64)) begin
      trace[tn] = ctl;
      tn = tn + 1;
    end
    prev_ctl = ctl;
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic send(input bit to_bare, input logic [15:0] key, input bit arm, input bit on);
    @(negedge clk);
    wr_key = key; wr_arm = arm; wr_on = on;
    if (to_bare) wr_valid_b = 1'b1; else wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_valid_b = 1'b0;
  endtask

  task automatic wait_evt(input bit bare, output int n);
    n = 1;
    while (!(bare ? done_b : (done || err)) && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0; lock_b_low = 1'b0; lock_prot_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int base;
    wr_valid = 1'b0; wr_valid_b = 1'b0; wr_key = '0; wr_arm = 1'b0; wr_on = 1'b0;
    do_reset();

    // reset state
    chk(ctl == 12'hF12, "R2 ctl reset", ctl, 12'hF12);
    chk(prot_en == PMASK, "R2 prot reset", prot_en, PMASK);
    chk({done, err, busy, is_on} == 4'b0, "R2 flags reset", {done, err, busy, is_on}, 0);

    // bad key and missing enable bit are ignored
    send(0, 16'h0B17, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && ctl == 12'hF12, "R1 wrong key", ctl, 12'hF12);
    send(0, KEY, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && ctl == 12'hF12, "R1 enable bit clear", ctl, 12'hF12);

    // request for current state completes at once
    send(0, KEY, 1'b1, 1'b0);
    chk(done == 1'b1, "R10 redundant done", done, 1);
    chk(ctl == 12'hF12, "R10 redundant no change", ctl, 12'hF12);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", done, 0);

    // full power-up
    base = tn;
    send(0, KEY, 1'b1, 1'b1);
    wait_evt(0, n);
    chk(done && !err, "R3 power-up completes", {done, err}, 2);
    chk(is_on == 1'b1, "R11 is_on with done", is_on, 1);
    chk(prot_en == 8'h00, "R7 protection released", prot_en, 0);
    chk(tn - base == 6, "R8 power-up step count", tn - base, 6);
    @(negedge clk);
    chk(done == 1'b0, "R11 done drops", done, 0);

    // power-down with an ignored request while busy
    send(0, KEY, 1'b1, 1'b0);
    @(negedge clk);
    send(0, KEY, 1'b1, 1'b1);
    wait_evt(0, n);
    chk(done && !is_on, "R6 power-down completes", {done, is_on}, 2);
    chk(prot_en == PMASK, "R7 protection asserted", prot_en, PMASK);
    repeat (20) @(negedge clk);
    chk(!busy && !is_on && (tn - base == 12), "R10 busy request ignored", tn - base, 12);

    // walk the step table
    for (int i = 0; i < 12; i++) begin
      chk(trace[base + i] == TRACE_EXP[i], (i < 6) ? "R3 R8 up step" : "R6 R8 down step",
          trace[base + i], TRACE_EXP[i]);
    end

    // timeout on a mixed status pair
    do_reset();
    lock_b_low = 1'b1;
    send(0, KEY, 1'b1, 1'b1);
    wait_evt(0, n);
    chk(err && !done, "R9 timeout error without done", {err, done}, 2);
    chk(n == 19, "R4 R9 mixed status times out", n, 19);
    chk(ctl == 12'hF1E && !busy && !is_on, "R9 ctl frozen", ctl, 12'hF1E);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R9 error sticky", err, 1);

    // timeout on bus-protection acknowledge
    do_reset();
    send(0, KEY, 1'b1, 1'b1);
    wait_evt(0, n);
    lock_prot_low = 1'b1;
    send(0, KEY, 1'b1, 1'b0);
    wait_evt(0, n);
    chk(err && n == 18, "R7 R9 protection ack timeout", n, 18);
    chk(ctl == 12'h00D && prot_en == PMASK && is_on, "R9 state kept", ctl, 12'h00D);

    // zero masks: skipped handshake, untouched SRAM bits
    do_reset();
    chk(ctl_b == 12'h012, "R2 bare reset", ctl_b, 12'h012);
    send(1, KEY, 1'b1, 1'b1);
    wait_evt(1, n);
    chk(n == 10, "R7 bare up skips protection", n, 10);
    chk(ctl_b[11:8] == 4'h0 && ctl_b == 12'h00D, "R5 bare SRAM untouched", ctl_b, 12'h00D);
    chk(prot_en_b == '0, "R7 bare prot idle", prot_en_b, 0);
    send(1, KEY, 1'b1, 1'b0);
    wait_evt(1, n);
    chk(n == 10 && ctl_b == 12'h012, "R6 bare power-down", n, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule